// File: doc/BRIEF.md
# Status-Bus Slave Controller

This block sits on the local bus of a 16-bit processor with 24-bit addresses and acts as the bus slave. The processor announces each bus cycle with two active-low status lines and two qualifiers: memory-versus-I/O, and code-versus-interrupt-acknowledge. The controller runs on the double-rate processor clock, so one controller cycle is one clock phase. A `phaseTwo` input marks the second phase of each processor state, and it alternates every cycle. When the status lines leave the idle code, the controller latches the status, qualifiers, address and byte enables in the second phase of the send state. It then classifies the cycle.

Reads and writes to memory and I/O space, and instruction fetches, are passed on to an internal responder as a one-cycle request. The request carries a kind code, the address and the lane enables. Read data comes back on a response strobe. The controller steers it onto the byte lanes and pulls the active-low ready line for one phase-two cycle. On writes it captures the enabled lanes, packs them into a word, issues the request and ends the bus cycle at once. Interrupt-acknowledge cycles are handed to a separate responder with a single-cycle start pulse. Halt, shutdown and reserved codes set sticky flags, and the controller then goes quiet until reset.

Top module: `status_bus_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `readyN` is 1, `reqValid` and `intaStart` are 0, `dataOe` is 0, and all three flags are 0.
- R2: A cycle is latched only on a clock edge that ends a cycle with `phaseTwo`=1 while `statusN` is not 2'b11. A status code that is held only during a phase-one cycle, or the idle code 2'b11, causes no request and no ready.
- R3: With `statusN`={S1n,S0n}, the decode is as follows. {cod,mem}=11 with 10 is a fetch (kind 4). {cod,mem}=10 with 10 is an I/O read (2), and with 01 an I/O write (3). {cod,mem}=01 with 10 is a memory read (0), and with 01 a memory write (1). `reqKind` presents the latched kind while `reqValid` is high. Each serviced cycle gives exactly one `reqValid` pulse.
- R4: For I/O reads and writes, `reqAddr` carries address bits 15:0 with bits 23:16 forced to zero. Other kinds carry the full 24-bit address.
- R5: `reqLanes[1]` is the inverse of `bheN`, and `reqLanes[0]` is the inverse of address bit 0.
- R6: In the ready cycle of a read, `dataOe` equals the lane enables. With both lanes enabled, `dataOut` is the response word. With one lane enabled, response bits 7:0 appear on that lane.
- R7: For read kinds, `reqValid` is high in the first cycle after the latch edge. If `rspValid` arrives in that same cycle, `readyN` is 0 in the second cycle after the latch edge. `readyN` is low for exactly one cycle, always a phase-two cycle, and `dataOe` is nonzero only then.
- R8: A read waits for `rspValid`. If the response arrives in cycle 1+d after the latch edge, `readyN` falls in cycle 2+d when d is even and in cycle 3+d when d is odd.
- R9: For write kinds, `dataIn` is captured at the end of the first cycle after the latch edge. In the second cycle, `readyN` is 0 and `reqValid` is 1. `reqWrData` then holds either the full word (both lanes) or the single enabled lane's byte in bits 7:0 with zeros above.
- R10: {cod,mem}=00 with `statusN`=00 is an interrupt acknowledge. `intaStart` is 1 for the single cycle after the latch edge, with no `reqValid` and no `readyN`.
- R11: {cod,mem}=01 with `statusN`=00 sets `haltFlag` when address bit 1 is 1, and `shutdownFlag` when it is 0. The flag is visible in the second cycle after the latch edge. From then until reset, no request, ready or acknowledge start is produced.
- R12: Every other qualifier and status combination sets `errorFlag`, with the same timing and the same silence until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate processor clock, one cycle per phase |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseTwo | input | 1 | High during the second phase of a processor state |
| statusN | input | 2 | Active-low status {S1n,S0n}; 2'b11 is idle |
| memNotIo | input | 1 | High for memory space, low for I/O or acknowledge |
| codNotInta | input | 1 | Low for data cycles, acknowledge and halt codes |
| bheN | input | 1 | Active-low high-byte enable |
| addrIn | input | 24 | Processor address bus |
| dataIn | input | 16 | Processor write data |
| dataOut | output | 16 | Read data toward the processor |
| dataOe | output | 2 | Per-lane output enable {high,low} |
| readyN | output | 1 | Active-low cycle-end signal |
| reqValid | output | 1 | One-cycle request strobe to the internal responder |
| reqKind | output | 4 | Latched cycle kind code |
| reqAddr | output | 24 | Latched address, masked for I/O |
| reqLanes | output | 2 | Latched lane enables {high,low} |
| reqWrData | output | 16 | Packed write word |
| rspValid | input | 1 | Read data valid from the responder |
| rspData | input | 16 | Read data word from the responder |
| intaStart | output | 1 | Hand-off pulse to the acknowledge responder |
| haltFlag | output | 1 | Sticky halt indication |
| shutdownFlag | output | 1 | Sticky shutdown indication |
| errorFlag | output | 1 | Sticky reserved-code indication |

## Verification
The hardest case to reach is a read whose response lands in a phase-two cycle. The controller must hold the data and skip one phase before it pulls ready. The bench therefore sweeps the response delay over even and odd values, on directed and random reads. For each read it predicts the exact cycle in which ready should fall. The sticky stop states end all further service, so they are exercised last, each one followed by a fresh reset. A normal read is then issued to show that nothing answers it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [3:0] {
    CK_MEMRD = 4'd0,
    CK_MEMWR = 4'd1,
    CK_IORD  = 4'd2,
    CK_IOWR  = 4'd3,
    CK_FETCH = 4'd4,
    CK_INTA  = 4'd5,
    CK_HALT  = 4'd6,
    CK_SHUT  = 4'd7,
    CK_RSVD  = 4'd8
  } cycKind_t;

  typedef struct packed {
    logic latchCycle;
    logic captWrite;
    logic captRead;
  } dpCtrl_t;

  function automatic logic isReadKind(cycKind_t k);
    return (k == CK_MEMRD) || (k == CK_IORD) || (k == CK_FETCH);
  endfunction

  function automatic logic isWriteKind(cycKind_t k);
    return (k == CK_MEMWR) || (k == CK_IOWR);
  endfunction

  function automatic logic isIoKind(cycKind_t k);
    return (k == CK_IORD) || (k == CK_IOWR);
  endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic [1:0] statusN,
  input  logic       memNotIo,
  input  logic       codNotInta,
  input  logic       addrBit1,
  output cycKind_t   kind
);
  localparam logic [1:0] ST_READ  = 2'b10;  // S1 high, S0 low
  localparam logic [1:0] ST_WRITE = 2'b01;  // S1 low, S0 high
  localparam logic [1:0] ST_BOTH  = 2'b00;

  always_comb begin
    kind = CK_RSVD;
    unique case ({codNotInta, memNotIo})
      2'b11: if (statusN == ST_READ) kind = CK_FETCH;
      2'b10: begin
        if (statusN == ST_READ)       kind = CK_IORD;
        else if (statusN == ST_WRITE) kind = CK_IOWR;
      end
      2'b01: begin
        if (statusN == ST_READ)       kind = CK_MEMRD;
        else if (statusN == ST_WRITE) kind = CK_MEMWR;
        else if (statusN == ST_BOTH)  kind = addrBit1 ? CK_HALT : CK_SHUT;
      end
      default: if (statusN == ST_BOTH) kind = CK_INTA;
    endcase
  end
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 16
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  cycKind_t              decKind,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic                  bheN,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [DATA_W-1:0]     rspData,
  input  logic                  driveRead,
  output cycKind_t              kind,
  output logic [ADDR_W-1:0]     reqAddr,
  output logic [DATA_W/8-1:0]   reqLanes,
  output logic [DATA_W-1:0]     reqWrData,
  output logic [DATA_W-1:0]     dataOut,
  output logic [DATA_W/8-1:0]   dataOe
);
  localparam int LANES = DATA_W / 8;

  cycKind_t          kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  lanesQ;
  logic [DATA_W-1:0] wrWordQ;
  logic [DATA_W-1:0] rdWordQ;
  logic [ADDR_W-1:0] addrMasked;
  logic [LANES-1:0]  laneEn;
  logic [DATA_W-1:0] packedWr;
  logic              singleLane;

  // high lane from the byte-high enable, low lane from the even address
  assign laneEn = {~bheN, ~addrIn[0]};

  always_comb begin
    addrMasked = addrIn;
    if (isIoKind(decKind))
      addrMasked = {{(ADDR_W-IO_ADDR_W){1'b0}}, addrIn[IO_ADDR_W-1:0]};
  end

  assign singleLane = ($countones(lanesQ) == 1);

  always_comb begin
    packedWr = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lanesQ[i]) begin
        if (singleLane) packedWr[7:0]     = dataIn[8*i +: 8];
        else            packedWr[8*i +: 8] = dataIn[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ   <= CK_MEMRD;
      addrQ   <= '0;
      lanesQ  <= '0;
      wrWordQ <= '0;
      rdWordQ <= '0;
    end else begin
      if (ctrl.latchCycle) begin
        kindQ  <= decKind;
        addrQ  <= addrMasked;
        lanesQ <= laneEn;
      end
      if (ctrl.captWrite) wrWordQ <= packedWr;
      if (ctrl.captRead)  rdWordQ <= rspData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign dataOut[8*g +: 8] = singleLane ? rdWordQ[7:0] : rdWordQ[8*g +: 8];
    assign dataOe[g]         = driveRead & lanesQ[g];
  end

  assign kind      = kindQ;
  assign reqAddr   = addrQ;
  assign reqLanes  = lanesQ;
  assign reqWrData = wrWordQ;
endmodule

// File: rtl/sbs_control.sv
module sbs_control
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseTwo,
  input  logic [1:0] statusN,
  input  cycKind_t   kind,
  input  logic       rspValid,
  output dpCtrl_t    ctrl,
  output logic       reqValid,
  output logic       readyN,
  output logic       driveRead,
  output logic       intaStart,
  output logic       haltFlag,
  output logic       shutdownFlag,
  output logic       errorFlag
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WAITRD, ST_DRIVE, ST_STOP
  } ctlState_t;

  ctlState_t state, stateNext;
  logic      haveData;
  logic      cycleStart;
  logic      rdKind, wrKind;

  assign rdKind     = isReadKind(kind);
  assign wrKind     = isWriteKind(kind);
  assign cycleStart = (state == ST_IDLE) && phaseTwo && (statusN != 2'b11);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (cycleStart) stateNext = ST_CMD;
      ST_CMD: begin
        if (rdKind)              stateNext = (rspValid && !phaseTwo) ? ST_DRIVE : ST_WAITRD;
        else if (wrKind)         stateNext = ST_DRIVE;
        else if (kind == CK_INTA) stateNext = ST_IDLE;
        else                     stateNext = ST_STOP;
      end
      ST_WAITRD: if ((haveData || rspValid) && !phaseTwo) stateNext = ST_DRIVE;
      ST_DRIVE:  stateNext = ST_IDLE;
      default:   stateNext = ST_STOP;
    endcase
  end

  always_comb begin
    ctrl.latchCycle = cycleStart;
    ctrl.captWrite  = (state == ST_CMD) && wrKind;
    ctrl.captRead   = ((state == ST_CMD) || (state == ST_WAITRD)) && rdKind
                      && rspValid && !haveData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      haveData     <= 1'b0;
      haltFlag     <= 1'b0;
      shutdownFlag <= 1'b0;
      errorFlag    <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.captRead)          haveData <= 1'b1;
      else if (state == ST_DRIVE) haveData <= 1'b0;
      if (state == ST_CMD) begin
        if (kind == CK_HALT) haltFlag     <= 1'b1;
        if (kind == CK_SHUT) shutdownFlag <= 1'b1;
        if (kind == CK_RSVD) errorFlag    <= 1'b1;
      end
    end
  end

  assign reqValid  = ((state == ST_CMD) && rdKind) || ((state == ST_DRIVE) && wrKind);
  assign readyN    = (state != ST_DRIVE);
  assign driveRead = (state == ST_DRIVE) && rdKind;
  assign intaStart = (state == ST_CMD) && (kind == CK_INTA);
endmodule

// File: rtl/status_bus_slave.sv
module status_bus_slave
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 16
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                phaseTwo,
  input  logic [1:0]          statusN,
  input  logic                memNotIo,
  input  logic                codNotInta,
  input  logic                bheN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [DATA_W/8-1:0] dataOe,
  output logic                readyN,
  output logic                reqValid,
  output logic [3:0]          reqKind,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [DATA_W/8-1:0] reqLanes,
  output logic [DATA_W-1:0]   reqWrData,
  input  logic                rspValid,
  input  logic [DATA_W-1:0]   rspData,
  output logic                intaStart,
  output logic                haltFlag,
  output logic                shutdownFlag,
  output logic                errorFlag
);
  cycKind_t decKind, kind;
  dpCtrl_t  ctrl;
  logic     driveRead;

  sbs_decode uDecode (
    .statusN    (statusN),
    .memNotIo   (memNotIo),
    .codNotInta (codNotInta),
    .addrBit1   (addrIn[1]),
    .kind       (decKind)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .decKind   (decKind),
    .addrIn    (addrIn),
    .bheN      (bheN),
    .dataIn    (dataIn),
    .rspData   (rspData),
    .driveRead (driveRead),
    .kind      (kind),
    .reqAddr   (reqAddr),
    .reqLanes  (reqLanes),
    .reqWrData (reqWrData),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

  sbs_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .phaseTwo     (phaseTwo),
    .statusN      (statusN),
    .kind         (kind),
    .rspValid     (rspValid),
    .ctrl         (ctrl),
    .reqValid     (reqValid),
    .readyN       (readyN),
    .driveRead    (driveRead),
    .intaStart    (intaStart),
    .haltFlag     (haltFlag),
    .shutdownFlag (shutdownFlag),
    .errorFlag    (errorFlag)
  );

  assign reqKind = kind;
endmodule

// File: rtl/status_bus_slave_checker.sv
module status_bus_slave_checker #(
  parameter int ADDR_W    = 24,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 16
)(
  input logic                clk,
  input logic                rstN,
  input logic                phaseTwo,
  input logic                readyN,
  input logic                reqValid,
  input logic [3:0]          reqKind,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [DATA_W/8-1:0] dataOe,
  input logic                intaStart,
  input logic                haltFlag,
  input logic                shutdownFlag,
  input logic                errorFlag
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (readyN && !reqValid && !intaStart && (dataOe == '0)));

  p_ready_phase2_r7: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |-> phaseTwo);

  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |=> readyN);

  p_oe_in_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe != '0) |-> !readyN);

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  p_io_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqKind == 4'd2 || reqKind == 4'd3))
      |-> (reqAddr[ADDR_W-1:IO_ADDR_W] == '0));

  p_inta_alone_r10: assert property (@(posedge clk) disable iff (!rstN)
    intaStart |-> (readyN && !reqValid));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haltFlag || shutdownFlag) |=> (haltFlag || shutdownFlag));

  p_error_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    errorFlag |=> errorFlag);

  p_stopped_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haltFlag || shutdownFlag || errorFlag) |-> (readyN && !reqValid && !intaStart));
endmodule

bind status_bus_slave status_bus_slave_checker #(
  .ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .DATA_W(DATA_W)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .phaseTwo     (phaseTwo),
  .readyN       (readyN),
  .reqValid     (reqValid),
  .reqKind      (reqKind),
  .reqAddr      (reqAddr),
  .dataOe       (dataOe),
  .intaStart    (intaStart),
  .haltFlag     (haltFlag),
  .shutdownFlag (shutdownFlag),
  .errorFlag    (errorFlag)
);

// File: tb/tb_status_bus_slave.sv
`timescale 1ns/1ps
module tb_status_bus_slave;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseTwo = 1'b0;
  logic [1:0]  statusN = 2'b11;
  logic        memNotIo = 1'b0;
  logic        codNotInta = 1'b0;
  logic        bheN = 1'b1;
  logic [23:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  dataOe;
  logic        readyN;
  logic        reqValid;
  logic [3:0]  reqKind;
  logic [23:0] reqAddr;
  logic [1:0]  reqLanes;
  logic [15:0] reqWrData;
  logic        rspValid = 1'b0;
  logic [15:0] rspData = '0;
  logic        intaStart;
  logic        haltFlag, shutdownFlag, errorFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  status_bus_slave dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance one cycle; inputs change and outputs are sampled 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
    phaseTwo = ~phaseTwo;
  endtask

  task automatic alignPhase1();
    do step(); while (phaseTwo != 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    statusN = 2'b11;
    rspValid = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  function automatic logic [3:0] expKind(input logic cod, input logic mio,
                                         input logic [1:0] st, input logic a1);
    case ({cod, mio})
      2'b11: return (st == 2'b10) ? 4'd4 : 4'd8;
      2'b10: return (st == 2'b10) ? 4'd2 : (st == 2'b01) ? 4'd3 : 4'd8;
      2'b01: return (st == 2'b10) ? 4'd0 : (st == 2'b01) ? 4'd1 :
                    (st == 2'b00) ? (a1 ? 4'd6 : 4'd7) : 4'd8;
      default: return (st == 2'b00) ? 4'd5 : 4'd8;
    endcase
  endfunction

  function automatic logic [15:0] expSteer(input logic [1:0] ln, input logic [15:0] w);
    case (ln)
      2'b11: return w;
      2'b10: return {w[7:0], 8'h00};
      2'b01: return {8'h00, w[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] expPack(input logic [1:0] ln, input logic [15:0] w);
    case (ln)
      2'b11: return w;
      2'b10: return {8'h00, w[15:8]};
      2'b01: return {8'h00, w[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] laneMask(input logic [1:0] ln);
    return {{8{ln[1]}}, {8{ln[0]}}};
  endfunction

  // one serviced bus cycle: read, write or acknowledge
  task automatic busCycle(input logic cod, input logic mio, input logic [1:0] st,
                          input logic [23:0] addr, input logic bhe,
                          input logic [15:0] wdata, input logic [15:0] rdata,
                          input int delay);
    logic [3:0]  k;
    logic [1:0]  ln;
    logic [23:0] aExp;
    int          rc, obsRc, nReq;
    logic [15:0] obsOut;
    logic [1:0]  obsOe;
    k    = expKind(cod, mio, st, addr[1]);
    ln   = {~bhe, ~addr[0]};
    aExp = (k == 4'd2 || k == 4'd3) ? {8'h00, addr[15:0]} : addr;
    alignPhase1();
    statusN = st; codNotInta = cod; memNotIo = mio; addrIn = addr; bheN = bhe;
    step();                       // send state, phase two
    step();                       // first command cycle
    statusN = 2'b11;
    addrIn  = $urandom;
    dataIn  = wdata;
    if (k == 4'd5) begin
      chk("R10", "intaStart", intaStart, 1'b1);
      chk("R10", "no request", reqValid, 1'b0);
      step();
      chk("R10", "intaStart single", intaStart, 1'b0);
      chk("R10", "no ready", readyN, 1'b1);
    end else if (k == 4'd1 || k == 4'd3) begin
      chk("R9", "no early request", reqValid, 1'b0);
      step();
      chk("R9", "write ready", readyN, 1'b0);
      chk("R9", "write request", reqValid, 1'b1);
      chk("R3", "write kind", reqKind, k);
      chk("R4", "write address", reqAddr, aExp);
      chk("R5", "write lanes", reqLanes, ln);
      chk("R9", "packed word", reqWrData, expPack(ln, wdata));
      step();
      chk("R7", "ready released", readyN, 1'b1);
    end else begin
      rc = (delay % 2 == 0) ? delay + 2 : delay + 3;
      obsRc = 0; nReq = 0; obsOut = '0; obsOe = '0;
      chk("R7", "read request", reqValid, 1'b1);
      chk("R3", "read kind", reqKind, k);
      chk("R4", "read address", reqAddr, aExp);
      chk("R5", "read lanes", reqLanes, ln);
      for (int cyc = 1; cyc <= rc + 1; cyc++) begin
        if (cyc > 1) step();
        rspValid = (cyc == 1 + delay);
        rspData  = (cyc == 1 + delay) ? rdata : 16'($urandom);
        if (reqValid) nReq++;
        if (!readyN && obsRc == 0) begin
          obsRc = cyc; obsOut = dataOut; obsOe = dataOe;
        end
      end
      rspValid = 1'b0;
      chk(delay == 0 ? "R7" : "R8", "ready cycle", obsRc, rc);
      chk("R3", "one request", nReq, 1);
      chk("R6", "lane enables", obsOe, ln);
      chk("R6", "steered data", obsOut & laneMask(ln), expSteer(ln, rdata));
    end
  endtask

  task automatic stopCycle(input logic cod, input logic mio, input logic [1:0] st,
                           input logic [23:0] addr, input string req,
                           input logic [2:0] flagsExp);
    int bad;
    alignPhase1();
    statusN = st; codNotInta = cod; memNotIo = mio; addrIn = addr; bheN = 1'b0;
    step();
    step();
    statusN = 2'b11;
    step();
    chk(req, "flags {halt,shut,err}", {haltFlag, shutdownFlag, errorFlag}, flagsExp);
    // a normal memory read must now go unanswered
    alignPhase1();
    statusN = 2'b10; codNotInta = 1'b0; memNotIo = 1'b1; addrIn = 24'h000100;
    step();
    step();
    statusN = 2'b11;
    rspValid = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (!readyN || reqValid || intaStart) bad++;
      step();
    end
    rspValid = 1'b0;
    chk(req, "silent after stop", bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (all) actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state
    repeat (2) step();
    chk("R1", "ready in reset", readyN, 1'b1);
    chk("R1", "req in reset", reqValid, 1'b0);
    chk("R1", "oe in reset", dataOe, 2'b00);
    chk("R1", "flags in reset", {haltFlag, shutdownFlag, errorFlag}, 3'b000);
    rstN = 1'b1;
    step();
    chk("R1", "ready after reset", readyN, 1'b1);
    chk("R1", "inta after reset", intaStart, 1'b0);

    // R2: status low only in phase one, then idle through phase two
    begin
      int bad = 0;
      alignPhase1();
      statusN = 2'b10; codNotInta = 1'b0; memNotIo = 1'b1;
      step();
      statusN = 2'b11;
      for (int i = 0; i < 8; i++) begin
        rspValid = 1'b1;
        if (!readyN || reqValid || intaStart) bad++;
        step();
      end
      rspValid = 1'b0;
      chk("R2", "no cycle from phase-one status or idle", bad, 0);
    end

    // directed corner cases
    busCycle(1'b0, 1'b1, 2'b10, 24'hABCDE0, 1'b0, 16'h0, 16'h1234, 0); // mem read, both
    busCycle(1'b0, 1'b1, 2'b10, 24'h000011, 1'b0, 16'h0, 16'h00A5, 0); // high only
    busCycle(1'b1, 1'b1, 2'b10, 24'h123456, 1'b1, 16'h0, 16'h5A3C, 1); // fetch, low, odd delay
    busCycle(1'b1, 1'b0, 2'b10, 24'hFE7700, 1'b0, 16'h0, 16'hBEEF, 2); // io read, even delay
    busCycle(1'b1, 1'b0, 2'b01, 24'h99C0DE, 1'b0, 16'hCAFE, 16'h0, 0); // io write
    busCycle(1'b0, 1'b1, 2'b01, 24'h400001, 1'b0, 16'h7788, 16'h0, 0); // mem write, high only
    busCycle(1'b0, 1'b1, 2'b01, 24'h400002, 1'b1, 16'h7788, 16'h0, 0); // mem write, low only
    busCycle(1'b0, 1'b0, 2'b00, 24'h000000, 1'b1, 16'h0, 16'h0, 0);    // acknowledge

    // random serviced cycles
    for (int n = 0; n < 80; n++) begin
      logic [2:0]  sel;
      logic        c, m;
      logic [1:0]  s;
      logic [23:0] a;
      logic        b;
      sel = 3'($urandom_range(0, 5));
      case (sel)
        3'd0: begin c = 1'b1; m = 1'b1; s = 2'b10; end
        3'd1: begin c = 1'b1; m = 1'b0; s = 2'b10; end
        3'd2: begin c = 1'b1; m = 1'b0; s = 2'b01; end
        3'd3: begin c = 1'b0; m = 1'b1; s = 2'b10; end
        3'd4: begin c = 1'b0; m = 1'b1; s = 2'b01; end
        default: begin c = 1'b0; m = 1'b0; s = 2'b00; end
      endcase
      a = 24'($urandom);
      b = 1'($urandom);
      if (b && a[0]) a[0] = 1'b0;
      busCycle(c, m, s, a, b, 16'($urandom), 16'($urandom), $urandom_range(0, 5));
    end

    // sticky stop states, each followed by reset
    stopCycle(1'b0, 1'b1, 2'b00, 24'h000002, "R11", 3'b100);
    doReset();
    stopCycle(1'b0, 1'b1, 2'b00, 24'h000000, "R11", 3'b010);
    doReset();
    stopCycle(1'b1, 1'b1, 2'b01, 24'h000000, "R12", 3'b001);
    doReset();
    stopCycle(1'b0, 1'b0, 2'b10, 24'h000000, "R12", 3'b001);
    doReset();
    busCycle(1'b0, 1'b1, 2'b10, 24'h00F0F0, 1'b0, 16'h0, 16'h4321, 3);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule